// File: doc/BRIEF.md
# Adaptive Synapse Weight Cell

This block is a single learning synapse for a relaxation-style neural network. It holds a signed weight as a sign bit and a magnitude. It records the correlation of its two neurons at the end of each of the two learning phases: the phase with the outputs clamped to the target, and the phase with the outputs running free. On an update strobe it moves the weight by exactly one step. The step goes up when the clamped correlation is higher than the free one, goes down when it is lower, and is skipped when the two are equal.

Each neuron state enters as one binarized bit, with 1 meaning +1 and 0 meaning −1. The product of two such states is +1 when the bits agree. Besides learning, the cell accepts three other commands. A direct weight write replaces the stored value. A global decay shrinks the magnitude toward zero. A link-enable input cuts this direction of the connection off, so networks can be asymmetric. When the link is cut, the driven weight reads zero but the stored weight is kept.

All commands are sampled on a rising clock edge. Their effect shows on the outputs after that edge.

Top module: `syn_weight_cell`

## Requirements
- R1: After a synchronous active-low reset, the stored weight is +0 (`w_sign`=0, `w_mag`=0).
- R2: A `cap_clamp` strobe latches the clamped correlation and a `cap_free` strobe latches the free correlation. The value latched is +1 when `pre_st` equals `post_st` and −1 otherwise. Changes of `pre_st`/`post_st` after the strobe do not alter the latched value.
- R3: An `upd_en` pulse with clamped = +1 and free = −1 raises the signed weight by one. With clamped = −1 and free = +1 it lowers the signed weight by one. When the two latched correlations are equal, the weight is unchanged.
- R4: A raise at +15 leaves the weight at +15, and a lowering at −15 leaves it at −15. A step crosses zero through +0, so −1 raised gives +0 and +0 lowered gives −1.
- R5: A `decay_en` pulse lowers a nonzero magnitude by one and keeps the sign, except that a result of magnitude 0 has sign 0. A zero weight stays +0.
- R6: A `load_en` pulse sets the weight to `load_sign`/`load_mag` on the next edge. A load of sign 1 with magnitude 0 is stored as +0.
- R7: When several commands arrive in one cycle, load wins over decay, and decay wins over the learning update.
- R8: With `link_en`=0, `drv_sign` and `drv_mag` are 0 and the stored weight is unaffected. With `link_en`=1 they equal `w_sign`/`w_mag`.
- R9: The stored weight never holds sign 1 with magnitude 0, and the stored signed value changes by at most one per cycle unless a load is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pre_st | input | 1 | Presynaptic neuron state (1 = +1, 0 = −1) |
| post_st | input | 1 | Postsynaptic neuron state (1 = +1, 0 = −1) |
| cap_clamp | input | 1 | Latch correlation at end of clamped phase |
| cap_free | input | 1 | Latch correlation at end of free phase |
| upd_en | input | 1 | Apply one learning step |
| decay_en | input | 1 | Global decay toward zero |
| load_en | input | 1 | Direct weight write |
| load_sign | input | 1 | Sign of written weight (1 = negative) |
| load_mag | input | MAG_W | Magnitude of written weight |
| link_en | input | 1 | Enable this connection direction |
| w_sign | output | 1 | Stored weight sign |
| w_mag | output | MAG_W | Stored weight magnitude |
| drv_sign | output | 1 | Driven weight sign (0 when link disabled) |
| drv_mag | output | MAG_W | Driven weight magnitude (0 when link disabled) |

## Verification
The stored weight goes straight to the ports, so a wrong step direction, a missed saturation or a wrong zero crossing shows on `w_sign`/`w_mag` one edge after the strobe that caused it. A wrong latched correlation stays hidden until the next update. It then shows as a step in the wrong direction, or as a step where none is due. The bench therefore changes the neuron states between capture and update. A priority error shows in the cycle after two commands collide, as a weight that matches the losing command.

// File: rtl/syn_pkg.sv
// Shared definitions for the synapse weight cell.
// Assumes a sign-magnitude weight with a symmetric range.
package syn_pkg;
    parameter int SYN_MAG_W = 4;

    // Command chosen for the weight register in a given cycle
    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_STEP  = 2'd1,
        CMD_DECAY = 2'd2,
        CMD_LOAD  = 2'd3
    } syn_cmd_e;
endpackage

// File: rtl/syn_corr_latch.sv
// Holds one phase correlation bit (1 = +1, 0 = -1).
// Captures the XNOR of the two neuron states when strobed; holds otherwise.
// Assumes the neuron states are settled in the strobe cycle.
module syn_corr_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic cap,
    input  logic pre_st,
    input  logic post_st,
    output logic corr
);
    // Register the product of the neuron states on a capture strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            corr <= 1'b1;
        else if (cap)
            corr <= ~(pre_st ^ post_st);
    end
endmodule

// File: rtl/syn_step_unit.sv
// Computes a one-step change of a sign-magnitude weight, up or down.
// Saturates at +/-MAX and never produces a negative zero.
// Purely combinational; assumes the input weight has no negative zero.
module syn_step_unit #(
    parameter int MAG_W = 4
) (
    input  logic             cur_sign,
    input  logic [MAG_W-1:0] cur_mag,
    input  logic             dir_up,
    output logic             nxt_sign,
    output logic [MAG_W-1:0] nxt_mag
);
    localparam logic [MAG_W-1:0] MAG_MAX = {MAG_W{1'b1}};

    // Choose the next value from the direction and the current position
    always_comb begin
        nxt_sign = cur_sign;
        nxt_mag  = cur_mag;
        if (dir_up) begin
            if (cur_sign) begin
                nxt_mag  = cur_mag - 1'b1;
                nxt_sign = (cur_mag != 1);
            end else if (cur_mag != MAG_MAX) begin
                nxt_mag = cur_mag + 1'b1;
            end
        end else begin
            if (!cur_sign && cur_mag == 0) begin
                nxt_sign = 1'b1;
                nxt_mag  = 1;
            end else if (!cur_sign) begin
                nxt_mag = cur_mag - 1'b1;
            end else if (cur_mag != MAG_MAX) begin
                nxt_mag = cur_mag + 1'b1;
            end
        end
    end
endmodule

// File: rtl/syn_weight_cell.sv
// Adaptive synapse: two phase correlation latches, a step unit and the
// weight register. Priority is load over decay over learning step.
// Assumes all strobes are single-cycle and synchronous to clk.
module syn_weight_cell #(
    parameter int MAG_W = syn_pkg::SYN_MAG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pre_st,
    input  logic             post_st,
    input  logic             cap_clamp,
    input  logic             cap_free,
    input  logic             upd_en,
    input  logic             decay_en,
    input  logic             load_en,
    input  logic             load_sign,
    input  logic [MAG_W-1:0] load_mag,
    input  logic             link_en,
    output logic             w_sign,
    output logic [MAG_W-1:0] w_mag,
    output logic             drv_sign,
    output logic [MAG_W-1:0] drv_mag
);
    import syn_pkg::*;

    logic             corr_c;
    logic             corr_f;
    logic             st_sign;
    logic [MAG_W-1:0] st_mag;
    logic             nx_sign;
    logic [MAG_W-1:0] nx_mag;
    syn_cmd_e         cmd;

    syn_corr_latch u_clamp (
        .clk(clk), .rst_n(rst_n), .cap(cap_clamp),
        .pre_st(pre_st), .post_st(post_st), .corr(corr_c)
    );

    syn_corr_latch u_free (
        .clk(clk), .rst_n(rst_n), .cap(cap_free),
        .pre_st(pre_st), .post_st(post_st), .corr(corr_f)
    );

    syn_step_unit #(.MAG_W(MAG_W)) u_step (
        .cur_sign(w_sign), .cur_mag(w_mag), .dir_up(corr_c),
        .nxt_sign(st_sign), .nxt_mag(st_mag)
    );

    // Arbitrate the commands of this cycle
    always_comb begin
        if (load_en)
            cmd = CMD_LOAD;
        else if (decay_en)
            cmd = CMD_DECAY;
        else if (upd_en && (corr_c != corr_f))
            cmd = CMD_STEP;
        else
            cmd = CMD_HOLD;
    end

    // Form the next weight for the selected command
    always_comb begin
        nx_sign = w_sign;
        nx_mag  = w_mag;
        case (cmd)
            CMD_LOAD: begin
                nx_mag  = load_mag;
                nx_sign = load_sign && (load_mag != 0);
            end
            CMD_DECAY: begin
                if (w_mag != 0) begin
                    nx_mag  = w_mag - 1'b1;
                    nx_sign = w_sign && (w_mag != 1);
                end
            end
            CMD_STEP: begin
                nx_sign = st_sign;
                nx_mag  = st_mag;
            end
            default: ;
        endcase
    end

    // Weight register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_sign <= 1'b0;
            w_mag  <= '0;
        end else begin
            w_sign <= nx_sign;
            w_mag  <= nx_mag;
        end
    end

    // Gate the driven weight with the connection enable
    always_comb begin
        drv_sign = link_en ? w_sign : 1'b0;
        drv_mag  = link_en ? w_mag  : '0;
    end
endmodule

// File: rtl/syn_weight_cell_chk.sv
// Property checker for the synapse weight cell, bound to every instance.
module syn_weight_cell_chk #(
    parameter int MAG_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             upd_en,
    input logic             decay_en,
    input logic             load_en,
    input logic             load_sign,
    input logic [MAG_W-1:0] load_mag,
    input logic             link_en,
    input logic             corr_c,
    input logic             corr_f,
    input logic             w_sign,
    input logic [MAG_W-1:0] w_mag,
    input logic             drv_sign,
    input logic [MAG_W-1:0] drv_mag
);
    logic armed;
    int   sval;
    int   sval_q;

    // Note one cycle out of reset so that $past has valid history
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    always_comb sval = w_sign ? -int'(w_mag) : int'(w_mag);

    // Previous signed value
    always_ff @(posedge clk) sval_q <= sval;

    AST_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> !(w_sign && w_mag == 0)); // R9

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(load_en)) |-> (sval - sval_q <= 1 && sval_q - sval <= 1)); // R9

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (w_mag == $past(load_mag) && w_sign == ($past(load_sign) && $past(load_mag) != 0))); // R6

    AST_DECAY_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (decay_en && !load_en && w_mag != 0) |=> (w_mag == $past(w_mag) - 1'b1)); // R5

    AST_EQUAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !decay_en && !load_en && corr_c == corr_f) |=> $stable(sval)); // R3

    AST_LINK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !link_en |-> (drv_sign == 1'b0 && drv_mag == 0)); // R8
endmodule

bind syn_weight_cell syn_weight_cell_chk #(.MAG_W(MAG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .decay_en(decay_en),
    .load_en(load_en), .load_sign(load_sign), .load_mag(load_mag),
    .link_en(link_en), .corr_c(corr_c), .corr_f(corr_f),
    .w_sign(w_sign), .w_mag(w_mag), .drv_sign(drv_sign), .drv_mag(drv_mag)
);

// File: tb/syn_weight_cell_test.sv
// Directed bench for the synapse weight cell; one task per scenario.
module syn_weight_cell_test;
    localparam int MW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pre_st = 1'b0, post_st = 1'b0;
    logic          cap_clamp = 1'b0, cap_free = 1'b0, upd_en = 1'b0;
    logic          decay_en = 1'b0, load_en = 1'b0, load_sign = 1'b0;
    logic [MW-1:0] load_mag = '0;
    logic          link_en = 1'b1;
    logic          w_sign, drv_sign;
    logic [MW-1:0] w_mag, drv_mag;

    int checks = 0;
    int errors = 0;

    syn_weight_cell #(.MAG_W(MW)) uut (
        .clk(clk), .rst_n(rst_n), .pre_st(pre_st), .post_st(post_st),
        .cap_clamp(cap_clamp), .cap_free(cap_free), .upd_en(upd_en),
        .decay_en(decay_en), .load_en(load_en), .load_sign(load_sign),
        .load_mag(load_mag), .link_en(link_en), .w_sign(w_sign),
        .w_mag(w_mag), .drv_sign(drv_sign), .drv_mag(drv_mag)
    );

    always #4 clk = ~clk;

    function automatic int wval();
        return w_sign ? -int'(w_mag) : int'(w_mag);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Wait one edge, then drop all strobes; outputs now show the result
    task automatic tick();
        @(negedge clk);
        cap_clamp = 0; cap_free = 0; upd_en = 0;
        decay_en = 0; load_en = 0;
    endtask

    task automatic load(input int v);
        load_en = 1; load_sign = (v < 0); load_mag = MW'(v < 0 ? -v : v);
        tick();
    endtask

    task automatic learn(input logic pc, qc, pf, qf);
        pre_st = pc; post_st = qc; cap_clamp = 1; tick();
        pre_st = pf; post_st = qf; cap_free = 1; tick();
        upd_en = 1; tick();
    endtask

    task automatic t_reset();
        chk("R1 sign", int'(w_sign), 0);
        chk("R1 mag", int'(w_mag), 0);
    endtask

    task automatic t_learn();
        load(3);
        learn(1, 1, 1, 0);  chk("R3 up", wval(), 4);
        learn(0, 1, 0, 0);  chk("R3 down", wval(), 3);
        learn(1, 1, 0, 0);  chk("R3 equal +1", wval(), 3);
        learn(1, 0, 0, 1);  chk("R3 equal -1", wval(), 3);
    endtask

    task automatic t_capture_hold();
        load(0);
        pre_st = 1; post_st = 1; cap_clamp = 1; tick();
        pre_st = 1; post_st = 0; cap_free = 1; tick();
        pre_st = 0; post_st = 0; tick();
        upd_en = 1; tick();
        chk("R2 latched held", wval(), 1);
        upd_en = 1; tick();
        chk("R2 repeat update", wval(), 2);
    endtask

    task automatic t_sat();
        load(15); learn(1, 1, 1, 0); chk("R4 top", wval(), 15);
        load(-15); learn(1, 0, 1, 1); chk("R4 bottom", wval(), -15);
        load(-1); learn(1, 1, 1, 0);
        chk("R4 cross up", wval(), 0); chk("R4 cross sign", int'(w_sign), 0);
        load(0); learn(1, 0, 1, 1); chk("R4 cross down", wval(), -1);
    endtask

    task automatic t_decay();
        load(-3); decay_en = 1; tick(); chk("R5 neg", wval(), -2);
        load(5); decay_en = 1; tick(); chk("R5 pos", wval(), 4);
        load(0); decay_en = 1; tick(); chk("R5 zero", wval(), 0);
        load(-1); decay_en = 1; tick(); chk("R5 to zero sign", int'(w_sign), 0);
    endtask

    task automatic t_load();
        load(-7); chk("R6 load", wval(), -7);
        load_en = 1; load_sign = 1; load_mag = 0; tick();
        chk("R6 neg zero sign", int'(w_sign), 0);
        chk("R9 no neg zero", int'(w_mag), 0);
    endtask

    task automatic t_prio();
        load(4);
        pre_st = 1; post_st = 1; cap_clamp = 1; tick();
        pre_st = 1; post_st = 0; cap_free = 1; tick();
        load_en = 1; load_sign = 0; load_mag = 9; decay_en = 1; upd_en = 1; tick();
        chk("R7 load first", wval(), 9);
        decay_en = 1; upd_en = 1; tick();
        chk("R7 decay over step", wval(), 8);
    endtask

    task automatic t_link();
        load(-6);
        link_en = 0; #1;
        chk("R8 off sign", int'(drv_sign), 0);
        chk("R8 off mag", int'(drv_mag), 0);
        tick();
        chk("R8 stored kept", wval(), -6);
        link_en = 1; #1;
        chk("R8 on sign", int'(drv_sign), 1);
        chk("R8 on mag", int'(drv_mag), 6);
    endtask

    initial begin : watchdog
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_learn();
        t_capture_hold();
        t_sat();
        t_decay();
        t_load();
        t_prio();
        t_link();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule